// File: doc/BRIEF.md
# Ternary Table Maintenance Sequencer

This block carries out the table-maintenance commands for a ternary search array and the external memory attached to it. It takes one command per cycle on a request strobe and drives a write port toward the search array. It also drives chip-enable, write-enable, address and data toward the associated memory. Plain entry writes take their address from the request. With the advance strobe raised, a write takes its address from an internal counter instead, so a table can be streamed in with no length limit. A dual write updates an array entry and the memory word at the same index in one cycle.

The learn command needs no address from the requester. The block keeps its own record of which entries are in use. It selects the lowest free entry and writes a preloaded comparand into that entry. It then writes the learn's memory data to the matching memory address and records the index in a result register. The register-select field is read on two cycles in a row: on the command cycle it names the comparand register, and on the next cycle it names the result register. The block reports busy for the whole learn and ignores requests during that time. The search array and the external memory themselves sit outside this block.

Top module: `cam_maint_ctrl`

## Requirements
- R1: Command code 1 with the advance strobe low writes `key_i` into the entry at `addr_i`. In the cycle after the request, `cam_we_o` is high with that address and key, and the entry is then counted as in use.
- R2: Command code 1 with the advance strobe high writes at the burst counter's address and then steps the counter. A code-1 write with the strobe low loads the counter with `addr_i`+1. The counter wraps from ENTRIES-1 to 0, and a burst may run any number of writes.
- R3: Command code 3 raises `mem_ce_o` and `mem_we_o` for one cycle, with `addr_i` and `mdata_i` on the memory address and data outputs, while `cam_we_o` stays low. Memory write-enable is never high without chip-enable.
- R4: Command code 4 writes `key_i` into the array entry at `addr_i` and writes `mdata_i` to the memory at the same address, in the same cycle, and marks the entry in use.
- R5: Command code 5 starts a learn. `sel_i` picks the comparand register on the command cycle and the result register on the following cycle. `busy_o` is high for the two cycles after the command edge, and the learn's outputs appear in the third cycle, when `busy_o` is low again.
- R6: A learn writes into the lowest-numbered entry that is not in use. It puts the selected comparand on `cam_key_o` and puts the `mdata_i` value sampled with the command on the memory data output. It writes both the array and the memory at that index, and marks the entry in use.
- R7: A successful learn stores {1, index} in the selected result register. Command code 6 returns result register `sel_i` on `rd_data_o`, with the found bit as the MSB and the index below it, together with a one-cycle `rd_valid_o`.
- R8: A learn with every entry in use pulses `full_err_o` for one cycle. It writes nothing to the array or the memory and leaves the result register unchanged.
- R9: A request that arrives while `busy_o` is high is ignored.
- R10: Command code 0 frees the entry at `addr_i` and pulses `cam_inval_o` with that address on `cam_addr_o`. Command code 2 loads `key_i` into comparand register `sel_i`. Code 7 does nothing.
- R11: After reset all strobes and `busy_o` are low, every entry is free, every result register reads 0 and the burst counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| sel_i | input | SEL_W | Register select (comparand, then result, for a learn) |
| adv_i | input | 1 | Take the write address from the burst counter |
| addr_i | input | IDX_W | Entry or memory address |
| key_i | input | KEY_W | Entry key or comparand value |
| mdata_i | input | MD_W | External memory data |
| busy_o | output | 1 | Learn in progress |
| cam_we_o | output | 1 | Array write strobe |
| cam_inval_o | output | 1 | Array entry free strobe |
| cam_addr_o | output | IDX_W | Array entry address |
| cam_key_o | output | KEY_W | Array write key |
| mem_ce_o | output | 1 | Memory chip enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | IDX_W | Memory address |
| mem_data_o | output | MD_W | Memory write data |
| full_err_o | output | 1 | Learn found no free entry |
| rd_valid_o | output | 1 | Result read data valid |
| rd_data_o | output | IDX_W+1 | Found bit and index of a result register |

## Verification
The bench fills the table with a burst that starts mid-range and wraps past the last entry; a counter that failed to wrap would write out of range and leave the low entries empty. It frees every entry in descending order and then learns repeatedly. Each learn must return indices in ascending order: an encoder with the wrong priority would pick the highest free slot. Learns against a full table must pulse the error and leave the result register unchanged; a design that wrote anyway would overwrite a live entry. A write issued during a learn must leave no trace, which the next learn proves by reusing that slot; a design that obeyed the write would mark the slot in use and skip it.

// File: rtl/cam_maint_pkg.sv
package cam_maint_pkg;
  typedef enum logic [2:0] {
    OP_INVAL   = 3'd0,
    OP_CAM_WR  = 3'd1,
    OP_CMP_LD  = 3'd2,
    OP_MEM_WR  = 3'd3,
    OP_DUAL_WR = 3'd4,
    OP_LEARN   = 3'd5,
    OP_RES_RD  = 3'd6,
    OP_NONE    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL2 = 2'd1,
    ST_EXEC = 2'd2
  } lrn_st_e;
endpackage

// File: rtl/cam_burst_ctr.sv
module cam_burst_ctr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] cnt_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] inc_wrap(input logic [IDX_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= inc_wrap(load_val_i);
    else if (step_i) cnt_o <= inc_wrap(cnt_o);
  end
endmodule

// File: rtl/cam_free_finder.sv
module cam_free_finder #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] in_use_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  // descending scan so the lowest free index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!in_use_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cam_reg_bank.sv
module cam_reg_bank #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs[g] <= '0;
      else if (we_i && wsel_i == SEL_W'(g))        regs[g] <= wdata_i;
    end
  end

  assign rdata_o = regs[rsel_i];
endmodule

// File: rtl/cam_maint_ctrl.sv
module cam_maint_ctrl
  import cam_maint_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 8,
  parameter int MD_W    = 8,
  parameter int NREG    = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       cmd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [MD_W-1:0]  mdata_i,
  output logic             busy_o,
  output logic             cam_we_o,
  output logic             cam_inval_o,
  output logic [IDX_W-1:0] cam_addr_o,
  output logic [KEY_W-1:0] cam_key_o,
  output logic             mem_ce_o,
  output logic             mem_we_o,
  output logic [IDX_W-1:0] mem_addr_o,
  output logic [MD_W-1:0]  mem_data_o,
  output logic             full_err_o,
  output logic             rd_valid_o,
  output logic [IDX_W:0]   rd_data_o
);
  lrn_st_e          st_q;
  logic [SEL_W-1:0] cmp_sel_q, res_sel_q;
  logic [MD_W-1:0]  mdata_q;
  logic [ENTRIES-1:0] in_use_q;

  op_e              op;
  logic             accept;
  logic [IDX_W-1:0] burst_cnt;
  logic [IDX_W-1:0] wr_addr;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [KEY_W-1:0] cmp_rdata;
  logic [IDX_W:0]   res_rdata;
  logic             exec_hit;

  assign op       = op_e'(cmd_i);
  assign accept   = req_i && (st_q == ST_IDLE);
  assign wr_addr  = adv_i ? burst_cnt : addr_i;
  assign exec_hit = (st_q == ST_EXEC) && free_found;
  assign busy_o   = (st_q != ST_IDLE);

  cam_burst_ctr #(.ENTRIES(ENTRIES)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && op == OP_CAM_WR && !adv_i),
    .load_val_i (addr_i),
    .step_i     (accept && op == OP_CAM_WR && adv_i),
    .cnt_o      (burst_cnt)
  );

  cam_free_finder #(.ENTRIES(ENTRIES)) u_free (
    .in_use_i (in_use_q),
    .found_o  (free_found),
    .idx_o    (free_idx)
  );

  cam_reg_bank #(.N(NREG), .W(KEY_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (accept && op == OP_CMP_LD),
    .wsel_i  (sel_i),
    .wdata_i (key_i),
    .rsel_i  (cmp_sel_q),
    .rdata_o (cmp_rdata)
  );

  cam_reg_bank #(.N(NREG), .W(IDX_W + 1)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (exec_hit),
    .wsel_i  (res_sel_q),
    .wdata_i ({1'b1, free_idx}),
    .rsel_i  (sel_i),
    .rdata_o (res_rdata)
  );

  // learn sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cmp_sel_q <= '0;
      res_sel_q <= '0;
      mdata_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept && op == OP_LEARN) begin
          st_q      <= ST_SEL2;
          cmp_sel_q <= sel_i;
          mdata_q   <= mdata_i;
        end
        ST_SEL2: begin
          res_sel_q <= sel_i;
          st_q      <= ST_EXEC;
        end
        ST_EXEC: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // occupancy map
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_use_q <= '0;
    else if (exec_hit) in_use_q[free_idx] <= 1'b1;
    else if (accept) begin
      case (op)
        OP_INVAL:   in_use_q[addr_i]  <= 1'b0;
        OP_CAM_WR:  in_use_q[wr_addr] <= 1'b1;
        OP_DUAL_WR: in_use_q[addr_i]  <= 1'b1;
        default: ;
      endcase
    end
  end

  // registered output port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cam_we_o    <= 1'b0;
      cam_inval_o <= 1'b0;
      cam_addr_o  <= '0;
      cam_key_o   <= '0;
      mem_ce_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      full_err_o  <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      cam_we_o    <= 1'b0;
      cam_inval_o <= 1'b0;
      mem_ce_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      full_err_o  <= 1'b0;
      rd_valid_o  <= 1'b0;
      if (st_q == ST_EXEC) begin
        if (free_found) begin
          cam_we_o   <= 1'b1;
          cam_addr_o <= free_idx;
          cam_key_o  <= cmp_rdata;
          mem_ce_o   <= 1'b1;
          mem_we_o   <= 1'b1;
          mem_addr_o <= free_idx;
          mem_data_o <= mdata_q;
        end else begin
          full_err_o <= 1'b1;
        end
      end else if (accept) begin
        case (op)
          OP_INVAL: begin
            cam_inval_o <= 1'b1;
            cam_addr_o  <= addr_i;
          end
          OP_CAM_WR: begin
            cam_we_o   <= 1'b1;
            cam_addr_o <= wr_addr;
            cam_key_o  <= key_i;
          end
          OP_MEM_WR: begin
            mem_ce_o   <= 1'b1;
            mem_we_o   <= 1'b1;
            mem_addr_o <= addr_i;
            mem_data_o <= mdata_i;
          end
          OP_DUAL_WR: begin
            cam_we_o   <= 1'b1;
            cam_addr_o <= addr_i;
            cam_key_o  <= key_i;
            mem_ce_o   <= 1'b1;
            mem_we_o   <= 1'b1;
            mem_addr_o <= addr_i;
            mem_data_o <= mdata_i;
          end
          OP_RES_RD: begin
            rd_valid_o <= 1'b1;
            rd_data_o  <= res_rdata;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cam_maint_chk.sv
module cam_maint_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             cam_we_o,
  input logic             cam_inval_o,
  input logic [IDX_W-1:0] cam_addr_o,
  input logic             mem_ce_o,
  input logic             mem_we_o,
  input logic [IDX_W-1:0] mem_addr_o,
  input logic             full_err_o,
  input logic             rd_valid_o
);
  a_r3_we_has_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_ce_o);

  a_r4_dual_addr_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cam_we_o && mem_we_o) |-> (cam_addr_o == mem_addr_o));

  a_r5_busy_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  a_r5_learn_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ((cam_we_o && mem_we_o) || full_err_o));

  a_r8_full_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_err_o |-> (!cam_we_o && !mem_we_o && !mem_ce_o));

  a_r9_quiet_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!rd_valid_o && !cam_inval_o && !cam_we_o && !mem_we_o));
endmodule

bind cam_maint_ctrl cam_maint_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .cam_we_o    (cam_we_o),
  .cam_inval_o (cam_inval_o),
  .cam_addr_o  (cam_addr_o),
  .mem_ce_o    (mem_ce_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .full_err_o  (full_err_o),
  .rd_valid_o  (rd_valid_o)
);

// File: tb/tb_cam_maint_ctrl.sv
module tb_cam_maint_ctrl;
  localparam int ENTRIES = 16;
  localparam int KEY_W   = 8;
  localparam int MD_W    = 8;
  localparam int NREG    = 4;
  localparam int IDX_W   = 4;
  localparam int SEL_W   = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic [2:0]       cmd_i = 3'd7;
  logic [SEL_W-1:0] sel_i = '0;
  logic             adv_i = 1'b0;
  logic [IDX_W-1:0] addr_i = '0;
  logic [KEY_W-1:0] key_i = '0;
  logic [MD_W-1:0]  mdata_i = '0;
  logic             busy_o, cam_we_o, cam_inval_o, mem_ce_o, mem_we_o;
  logic             full_err_o, rd_valid_o;
  logic [IDX_W-1:0] cam_addr_o, mem_addr_o;
  logic [KEY_W-1:0] cam_key_o;
  logic [MD_W-1:0]  mem_data_o;
  logic [IDX_W:0]   rd_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  cam_maint_ctrl #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .MD_W(MD_W), .NREG(NREG)) dut (
    .clk_i, .rst_ni, .req_i, .cmd_i, .sel_i, .adv_i, .addr_i, .key_i, .mdata_i,
    .busy_o, .cam_we_o, .cam_inval_o, .cam_addr_o, .cam_key_o,
    .mem_ce_o, .mem_we_o, .mem_addr_o, .mem_data_o,
    .full_err_o, .rd_valid_o, .rd_data_o
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic issue(input int c, input int s, input bit a, input int ad,
                       input int k, input int md);
    @(negedge clk_i);
    req_i = 1'b1; cmd_i = 3'(c); sel_i = SEL_W'(s); adv_i = a;
    addr_i = IDX_W'(ad); key_i = KEY_W'(k); mdata_i = MD_W'(md);
    @(negedge clk_i);
    req_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic cam_write(input string r, input bit a, input int ad, input int k,
                           input int exp_addr);
    issue(1, 0, a, ad, k, 0);
    chk({r, " cam_we"}, int'(cam_we_o), 1);
    chk({r, " addr"}, int'(cam_addr_o), exp_addr);
    chk({r, " key"}, int'(cam_key_o), k & 8'hFF);
    chk({r, " mem_we idle"}, int'(mem_we_o), 0);
  endtask

  task automatic read_res(input string r, input int rs, input int exp);
    issue(6, rs, 0, 0, 0, 0);
    chk({r, " rd_valid"}, int'(rd_valid_o), 1);
    chk({r, " rd_data"}, int'(rd_data_o), exp);
  endtask

  task automatic inval(input int ad);
    issue(0, 0, 0, ad, 0, 0);
    chk("R10 inval strobe", int'(cam_inval_o), 1);
    chk("R10 inval addr", int'(cam_addr_o), ad);
  endtask

  // exp_idx < 0 means a full table is expected
  task automatic learn(input int cs, input int rs, input int md, input int exp_idx,
                       input int exp_key);
    issue(5, cs, 0, 0, 0, md);
    chk("R5 busy cycle 1", int'(busy_o), 1);
    sel_i = SEL_W'(rs);
    @(negedge clk_i);
    chk("R5 busy cycle 2", int'(busy_o), 1);
    chk("R5 no early write", int'(cam_we_o), 0);
    @(negedge clk_i);
    chk("R5 busy released", int'(busy_o), 0);
    if (exp_idx < 0) begin
      chk("R8 full_err", int'(full_err_o), 1);
      chk("R8 no cam write", int'(cam_we_o), 0);
      chk("R8 no mem write", int'(mem_we_o), 0);
    end else begin
      chk("R6 full_err low", int'(full_err_o), 0);
      chk("R6 cam_we", int'(cam_we_o), 1);
      chk("R6 lowest free index", int'(cam_addr_o), exp_idx);
      chk("R6 comparand key", int'(cam_key_o), exp_key);
      chk("R6 mem_we", int'(mem_we_o), 1);
      chk("R6 mem addr", int'(mem_addr_o), exp_idx);
      chk("R6 mem data", int'(mem_data_o), md & 8'hFF);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 busy", int'(busy_o), 0);
    chk("R11 cam_we", int'(cam_we_o), 0);
    chk("R11 mem_ce", int'(mem_ce_o), 0);
    chk("R11 mem_we", int'(mem_we_o), 0);
    chk("R11 full_err", int'(full_err_o), 0);
    chk("R11 rd_valid", int'(rd_valid_o), 0);
    for (int r = 0; r < NREG; r++) read_res("R11 result reg", r, 0);
    cam_write("R11 counter starts at 0", 1'b1, 9, 8'h11, 0);

    // R1 plain write, then R2 burst wrapping past the last entry
    cam_write("R1 direct write", 1'b0, 3, 8'h30, 3);
    for (int i = 0; i < ENTRIES - 1; i++)
      cam_write("R2 burst", 1'b1, 0, i * 7 + 1, (4 + i) % ENTRIES);

    // R8 full table
    issue(2, 2, 0, 0, 8'hA5, 0);
    learn(2, 1, 8'h77, -1, 0);
    read_res("R8 result unchanged", 1, 0);

    // R10/R6/R7 free two entries, learn picks lowest
    inval(9);
    inval(5);
    learn(2, 1, 8'h3C, 5, 8'hA5);
    read_res("R7 result reg 1", 1, 16 + 5);
    learn(2, 3, 8'h4D, 9, 8'hA5);
    read_res("R7 result reg 3", 3, 16 + 9);
    learn(2, 0, 8'h01, -1, 0);
    read_res("R8 result reg 0 untouched", 0, 0);

    // R3 memory-only write
    issue(3, 0, 0, 7, 0, 8'h42);
    chk("R3 mem_ce", int'(mem_ce_o), 1);
    chk("R3 mem_we", int'(mem_we_o), 1);
    chk("R3 mem addr", int'(mem_addr_o), 7);
    chk("R3 mem data", int'(mem_data_o), 8'h42);
    chk("R3 cam_we low", int'(cam_we_o), 0);

    // R4 dual write
    issue(4, 0, 0, 12, 8'h99, 8'h24);
    chk("R4 cam_we", int'(cam_we_o), 1);
    chk("R4 mem_we", int'(mem_we_o), 1);
    chk("R4 cam addr", int'(cam_addr_o), 12);
    chk("R4 mem addr", int'(mem_addr_o), 12);
    chk("R4 key", int'(cam_key_o), 8'h99);
    chk("R4 data", int'(mem_data_o), 8'h24);

    // R10 code 7 does nothing
    issue(7, 0, 0, 4, 8'hFF, 8'hFF);
    chk("R10 nop cam_we", int'(cam_we_o), 0);
    chk("R10 nop inval", int'(cam_inval_o), 0);
    chk("R10 nop mem_we", int'(mem_we_o), 0);

    // R9 request during learn ignored
    inval(2);
    inval(11);
    issue(2, 1, 0, 0, 8'h5A, 0);
    issue(5, 1, 0, 0, 0, 8'h66);
    sel_i = 2'd0;
    req_i = 1'b1; cmd_i = 3'd1; adv_i = 1'b0; addr_i = 4'd11; key_i = 8'hEE;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R9 write ignored while busy", int'(cam_we_o), 0);
    chk("R9 still busy", int'(busy_o), 1);
    @(negedge clk_i);
    chk("R9 learn index", int'(cam_addr_o), 2);
    chk("R9 learn key", int'(cam_key_o), 8'h5A);
    learn(1, 2, 8'h10, 11, 8'h5A);

    // sweep: free all descending, learns must come back ascending
    for (int i = ENTRIES - 1; i >= 0; i--) inval(i);
    issue(2, 0, 0, 0, 8'hC3, 0);
    for (int i = 0; i < ENTRIES; i++) begin
      learn(0, i % NREG, i + 100, i, 8'hC3);
      read_res("R7 sweep result", i % NREG, 16 + i);
    end
    learn(0, 0, 8'h00, -1, 0);
    read_res("R8 sweep result kept", 0, 16 + 12);

    finish_run();
  end
endmodule